// File: doc/BRIEF.md
# Sticky Error and Mode Status Register

This block holds the run-state of a serial controller. It keeps a mode bit, a master-select bit and six sticky error flags. Software never writes these bits directly. It writes a 16-bit command word in which every bit has its own set bit and its own clear bit. When the mode bit is 0, the controller is in configuration mode, where speed, word length and clock mode may be changed. When the mode bit is 1, the controller is in operational mode.

The error flags are also set by single-cycle event pulses from the shift engine and FIFOs. Five of those events are gated by per-error enable bits from the control register. The mode-error event is always captured. A flag stays set until software clears it. A single interrupt line is high while any flag is set. The busy indication from the shift engine is passed through into the status word.

Top module: `sticky_status_unit`

## Requirements
- R1: After reset, statusWord is 0x0000, cfgMode is 1 and errIrq is 0.
- R2: A command with bit 1 sets the mode bit (status bit 0) and bit 0 clears it. The new value shows one cycle after the write. cfgMode is always the inverse of status bit 0.
- R3: Command bit 3 sets the master-select bit (status bit 1) and command bit 2 clears it.
- R4: These command bits set error flags, shown at the given status bits:
  - bit 7: mode error, status bit 7
  - bits 12, 13, 14, 15: transmit overflow, receive overflow, abort and transmit underflow, status bits 8, 9, 10, 11
  - bit 5: receive underflow, status bit 12
- R5: Command bit 6 clears mode error. Bits 8 to 11 clear transmit overflow, receive overflow, abort and transmit underflow, in that order. Bit 4 clears receive underflow.
- R6: Any mix of set and clear bits in one write takes effect together. For example, 0x0F5A sets mode and master select and clears all six errors.
- R7: When one write carries both the set bit and the clear bit for the same status bit, that bit ends up 1.
- R8: The errEvent bits are: 0 mode, 1 transmit overflow, 2 receive overflow, 3 abort, 4 transmit underflow, 5 receive underflow. An event pulse sets its flag one cycle later. This applies only when the matching errMask bit is 1; errMask bits 0 to 4 belong to events 1 to 5. A mode-error event always sets its flag.
- R9: An error flag keeps its value with no clear command, however many cycles pass. If an enabled event and a clear for the same flag arrive in the same cycle, the flag is set.
- R10: errIrq is 1 exactly when any of status bits 7 to 12 is 1.
- R11: Status bit 13 follows busyIn in the same cycle. Status bits 2 to 6, 14 and 15 read 0.
- R12: When cmdWe is 0, cmdWord has no effect on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWe | input | 1 | Command word write strobe |
| cmdWord | input | 16 | Set/clear command bits |
| errEvent | input | 6 | Error event pulses from the shift engine and FIFOs |
| errMask | input | 5 | Per-error enable bits for events 1 to 5 |
| busyIn | input | 1 | Busy indication from the shift engine |
| statusWord | output | 16 | Status word |
| cfgMode | output | 1 | High while in configuration mode |
| errIrq | output | 1 | Error interrupt |

## Verification
A wrongly decoded command bit shows at statusWord one cycle after the write, in a status position other than the one the requirement names. A flag that is not sticky, or that ignores its enable, shows as a status bit or an errIrq that differs from the expected value at the next sample. A wrong priority between set and clear shows as a 0 where a 1 is due, also within one cycle. errIrq and cfgMode are compared at every check, so a broken derivation of either is caught at the first check that follows.

// File: rtl/sticky_status_pkg.sv
package sticky_status_pkg;
  localparam int CMD_W  = 16;
  localparam int STAT_W = 16;
  localparam int NUM_ERR = 6;
  localparam int NUM_GATED = NUM_ERR - 1;
  localparam int ERR_LSB = 7;
  localparam int BUSY_BIT = ERR_LSB + NUM_ERR;

  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic setMs;
    logic clrMs;
    logic [NUM_ERR-1:0] setErr;
    logic [NUM_ERR-1:0] clrErr;
  } cmdStrobe_t;
endpackage

// File: rtl/status_cmd_ctrl.sv
module status_cmd_ctrl
  import sticky_status_pkg::*;
(
  input  logic                 cmdWe,
  input  logic [CMD_W-1:0]     cmdWord,
  input  logic [NUM_ERR-1:0]   errEvent,
  input  logic [NUM_GATED-1:0] errMask,
  output cmdStrobe_t           strobe
);
  logic [NUM_ERR-1:0] cmdSet;
  logic [NUM_ERR-1:0] cmdClr;
  logic [NUM_ERR-1:0] evtGate;

  // error index: 0 mode, 1 txOvf, 2 rxOvf, 3 abort, 4 txUnd, 5 rxUnd
  assign cmdSet  = {cmdWord[5], cmdWord[15:12], cmdWord[7]};
  assign cmdClr  = {cmdWord[4], cmdWord[11:8], cmdWord[6]};
  assign evtGate = {errMask, 1'b1};

  always_comb begin
    strobe.setEn  = cmdWe & cmdWord[1];
    strobe.clrEn  = cmdWe & cmdWord[0];
    strobe.setMs  = cmdWe & cmdWord[3];
    strobe.clrMs  = cmdWe & cmdWord[2];
    strobe.setErr = ({NUM_ERR{cmdWe}} & cmdSet) | (errEvent & evtGate);
    strobe.clrErr = {NUM_ERR{cmdWe}} & cmdClr;
  end
endmodule

// File: rtl/status_flags_dp.sv
module status_flags_dp
  import sticky_status_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  cmdStrobe_t         strobe,
  output logic               enQ,
  output logic               msQ,
  output logic [NUM_ERR-1:0] errQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= 1'b0;
      msQ <= 1'b0;
    end else begin
      if (strobe.setEn)      enQ <= 1'b1;
      else if (strobe.clrEn) enQ <= 1'b0;
      if (strobe.setMs)      msQ <= 1'b1;
      else if (strobe.clrMs) msQ <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 errQ[i] <= 1'b0;
      else if (strobe.setErr[i]) errQ[i] <= 1'b1;
      else if (strobe.clrErr[i]) errQ[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sticky_status_unit.sv
module sticky_status_unit
  import sticky_status_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdWe,
  input  logic [CMD_W-1:0]     cmdWord,
  input  logic [NUM_ERR-1:0]   errEvent,
  input  logic [NUM_GATED-1:0] errMask,
  input  logic                 busyIn,
  output logic [STAT_W-1:0]    statusWord,
  output logic                 cfgMode,
  output logic                 errIrq
);
  cmdStrobe_t         strobe;
  logic               enQ;
  logic               msQ;
  logic [NUM_ERR-1:0] errQ;

  status_cmd_ctrl u_ctrl (
    .cmdWe(cmdWe), .cmdWord(cmdWord), .errEvent(errEvent),
    .errMask(errMask), .strobe(strobe)
  );

  status_flags_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .enQ(enQ), .msQ(msQ), .errQ(errQ)
  );

  always_comb begin
    statusWord = '0;
    statusWord[0] = enQ;
    statusWord[1] = msQ;
    statusWord[ERR_LSB +: NUM_ERR] = errQ;
    statusWord[BUSY_BIT] = busyIn;
  end

  assign cfgMode = ~enQ;
  assign errIrq  = |errQ;
endmodule

// File: rtl/sticky_status_chk.sv
module sticky_status_chk
  import sticky_status_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 cmdWe,
  input logic [CMD_W-1:0]     cmdWord,
  input logic [NUM_ERR-1:0]   errEvent,
  input logic [NUM_GATED-1:0] errMask,
  input logic                 busyIn,
  input logic [STAT_W-1:0]    statusWord,
  input logic                 cfgMode,
  input logic                 errIrq
);
  AST_EN_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    cmdWe && cmdWord[1] |=> statusWord[0]); // R7
  AST_EN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    cmdWe && cmdWord[0] && !cmdWord[1] |=> !statusWord[0]); // R2
  AST_MS_SET: assert property (@(posedge clk) disable iff (!rstN)
    cmdWe && cmdWord[3] |=> statusWord[1]); // R3
  AST_TXOVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    cmdWe && cmdWord[12] |=> statusWord[8]); // R4
  AST_TXOVF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    cmdWe && cmdWord[8] && !cmdWord[12] && !(errEvent[1] && errMask[0])
    |=> !statusWord[8]); // R5
  AST_MODE_EVT: assert property (@(posedge clk) disable iff (!rstN)
    errEvent[0] |=> statusWord[7]); // R8
  AST_RXOVF_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[9] && !(cmdWe && cmdWord[13]) && !errMask[1]
    |=> !statusWord[9]); // R8
  AST_RXUND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[12] && !(cmdWe && cmdWord[4]) |=> statusWord[12]); // R9
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWe |=> $stable(statusWord[1:0])); // R12
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    errIrq == (statusWord[12:7] != '0)); // R10
  AST_CFG_MODE: assert property (@(posedge clk) disable iff (!rstN)
    cfgMode == !statusWord[0]); // R2
  AST_BUSY_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[13] == busyIn); // R11
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[6:2] == '0 && statusWord[15:14] == '0); // R11
endmodule

bind sticky_status_unit sticky_status_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdWord(cmdWord),
  .errEvent(errEvent), .errMask(errMask), .busyIn(busyIn),
  .statusWord(statusWord), .cfgMode(cfgMode), .errIrq(errIrq)
);

// File: tb/sim_sticky_status_unit.sv
module sim_sticky_status_unit;
  localparam time CLK_HALF = 10ns;
  localparam int NVEC = 13;
  // {command, expected status} applied in order from reset
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h0002, 16'h0001},  // R2 set mode bit
    {16'h0008, 16'h0003},  // R3 set master select
    {16'hF0A0, 16'h1F83},  // R4 set all errors
    {16'h0100, 16'h1E83},  // R5 clear tx overflow
    {16'h0E50, 16'h0003},  // R5 clear remaining errors
    {16'h0001, 16'h0002},  // R2 clear mode bit
    {16'h0004, 16'h0000},  // R3 clear master select
    {16'h000C, 16'h0002},  // R7 set+clear master select
    {16'hF0A5, 16'h1F80},  // R6 clears and sets mixed
    {16'h0F50, 16'h0000},  // R5 clear all errors
    {16'h0003, 16'h0001},  // R7 set+clear mode bit
    {16'hFFF0, 16'h1F81},  // R7 set+clear all errors
    {16'h0F5A, 16'h0003}   // R6 combined write
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWe = 1'b0;
  logic [15:0] cmdWord = '0;
  logic [5:0] errEvent = '0;
  logic [4:0] errMask = '0;
  logic busyIn = 1'b0;
  logic [15:0] statusWord;
  logic cfgMode;
  logic errIrq;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(CLK_HALF) clk = ~clk;

  sticky_status_unit u0 (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdWord(cmdWord),
    .errEvent(errEvent), .errMask(errMask), .busyIn(busyIn),
    .statusWord(statusWord), .cfgMode(cfgMode), .errIrq(errIrq)
  );

  task automatic check(input string req, input logic [15:0] exp);
    logic expIrq;
    logic expCfg;
    expIrq = exp[12:7] != 6'd0;
    expCfg = ~exp[0];
    nChecks++;
    if (statusWord !== exp || errIrq !== expIrq || cfgMode !== expCfg) begin
      nFails++;
      $display("FAIL %s: status=%h irq=%b cfg=%b expected status=%h irq=%b cfg=%b",
               req, statusWord, errIrq, cfgMode, exp, expIrq, expCfg);
    end
  endtask

  task automatic writeCmd(input logic [15:0] w);
    @(negedge clk);
    cmdWe = 1'b1;
    cmdWord = w;
    @(negedge clk);
    cmdWe = 1'b0;
    cmdWord = '0;
  endtask

  task automatic pulseEvt(input logic [5:0] e, input logic [15:0] w, input logic we);
    @(negedge clk);
    errEvent = e;
    cmdWe = we;
    cmdWord = w;
    @(negedge clk);
    errEvent = '0;
    cmdWe = 1'b0;
    cmdWord = '0;
  endtask

  initial begin
    #(CLK_HALF * 2 * 100000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      writeCmd(VEC[i][31:16]);
      check("R2-R7 table", VEC[i][15:0]);
    end

    // R12: strobe low, command ignored
    @(negedge clk);
    cmdWord = 16'hFFFF;
    @(negedge clk);
    cmdWord = '0;
    check("R12", 16'h0003);

    // R11: busy mirrored in the same cycle
    busyIn = 1'b1;
    #1;
    check("R11", 16'h2003);
    busyIn = 1'b0;
    #1;
    check("R11", 16'h0003);

    // R8: all masked, only mode error captured
    errMask = 5'b00000;
    pulseEvt(6'h3F, 16'h0000, 1'b0);
    check("R8", 16'h0083);
    writeCmd(16'h0040);
    check("R8", 16'h0003);
    // R8: partial mask, tx overflow and abort enabled
    errMask = 5'b00101;
    pulseEvt(6'h3E, 16'h0000, 1'b0);
    check("R8", 16'h0503);
    // R9: sticky over many idle cycles with events gone
    errMask = 5'b00000;
    repeat (20) @(negedge clk);
    check("R9", 16'h0503);
    writeCmd(16'h0F50);
    check("R5", 16'h0003);
    // R8: all enabled
    errMask = 5'b11111;
    pulseEvt(6'h3E, 16'h0000, 1'b0);
    check("R8", 16'h1F03);
    writeCmd(16'h0F50);
    check("R10", 16'h0003);
    // R9: event and clear in the same cycle, event wins
    pulseEvt(6'h20, 16'h0010, 1'b1);
    check("R9", 16'h1003);
    writeCmd(16'h0010);
    check("R10", 16'h0003);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule